// File: doc/BRIEF.md
# Receive Buffer Pointer Tracker

This block follows received packets through an 8 KiB receive buffer addressed by 13 bits. The buffer holds two areas: one for packet headers and one for ORB data. When a packet starts, the block records where its header and its ORB data begin. When the packet completes, it moves its write positions forward by the packet's lengths. The CPU reports how far it has consumed each area by writing "used" pointers. The block marks the receiver busy when the header area has no room left, or when software forces it busy.

On every bus reset the block copies the current posted ORB-data position into a read-only snapshot. Software can then tell which ORB data arrived before the reset. The same byte-wide register port also carries a receive FIFO not-empty flag, a FIFO clear strobe, a run monitor and a force-busy control. Every pointer is split into a high byte and a low byte. Reading the high byte captures the low byte, so a two-access read returns one consistent value.

Top module: `rxbuf_ptr_track`

## Requirements
- R1: After reset every register at addresses 0x0 to 0xC reads 0x00 and `rx_busy` is low.
- R2: `pkt_start` loads the link header pointer (0x0/0x1) with the current header write position. `pkt_done` advances that position by `pkt_hdr_blocks` × 32 bytes, wrapping modulo 8192. Writes to 0x0/0x1 have no effect.
- R3: `pkt_start` loads the link ORB pointer (0x2/0x3) with the current ORB write position. `pkt_done` advances that position by `pkt_orb_quads` × 4 bytes, wrapping modulo 8192. The advanced position reads as the posted pointer (0x8/0x9). Writes to 0x2, 0x3, 0x8 and 0x9 have no effect.
- R4: A `bus_reset` pulse copies the posted ORB pointer, as it stood in that cycle, into the snapshot (0xA/0xB). A later reset overwrites the snapshot. Writes to 0xA/0xB have no effect.
- R5: The used header pointer (0x4 high, 0x5 low) keeps address bits [12:5] only. Bits [4:0] of the low byte and bits [7:5] of the high byte read 0, and writes to them are ignored.
- R6: The used ORB pointer (0x6 high, 0x7 low) keeps address bits [12:2] only. Bits [1:0] of the low byte and bits [7:5] of the high byte read 0, and writes to them are ignored.
- R7: Each pointer's high byte (even address) returns bits [12:8]. A read of the high byte latches the pair's low byte. A read of the odd address returns the latched byte.
- R8: In the control register (0xC), bit 3 reads 1 when the FIFO count is non-zero. Pushes stop counting at FIFO_DEPTH and pops stop at zero. Writing 1 to bit 2 empties the FIFO, and bit 2 always reads 0.
- R9: Control bit 1 reads 1 from the cycle after `pkt_start` until `pkt_done`.
- R10: Control bit 0 is read/write. `rx_busy` is high when bit 0 is set, or when the header write position plus 32 bytes equals the used header pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Bus reset pulse |
| pkt_start | input | 1 | Packet reception begins |
| pkt_done | input | 1 | Packet reception complete, lengths valid |
| pkt_hdr_blocks | input | HLEN_W | Header length in 32-byte blocks |
| pkt_orb_quads | input | OLEN_W | ORB data length in quadlets |
| fifo_push | input | 1 | One entry enters the receive FIFO |
| fifo_pop | input | 1 | One entry leaves the receive FIFO |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data while `reg_rd` is high, otherwise 0 |
| rx_busy | output | 1 | Receiver busy indication |

## Verification
The stimulus first sends packets with small, varied header and ORB lengths, which separates the start-time capture from the completion-time advance. It then sends long runs of large packets that carry both write positions past the end of the buffer. This exposes wrong wrap widths and wrong alignment scaling. All-ones writes to the used pointers show whether the masked bits are dropped. A high-byte read followed by a packet before the low-byte read shows whether the low byte was latched or read live. A bus reset in the same cycle as a completion shows which posted value the snapshot takes.

// File: rtl/rxbuf_ptr_track.sv
module rxbuf_ptr_track #(
  parameter int FIFO_DEPTH = 16,
  parameter int HLEN_W = 4,
  parameter int OLEN_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              pkt_start,
  input  logic              pkt_done,
  input  logic [HLEN_W-1:0] pkt_hdr_blocks,
  input  logic [OLEN_W-1:0] pkt_orb_quads,
  input  logic              fifo_push,
  input  logic              fifo_pop,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              rx_busy
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(FIFO_DEPTH);

  logic [7:0]    hdr_pos, lhdr, uhdr;
  logic [10:0]   orb_pos, lorb, uorb, brst;
  logic [CW-1:0] fifo_cnt;
  logic          run, force_busy;
  logic [7:0]    shadow, hi_byte, lo_byte;

  wire wr_ctl = reg_wr && reg_addr == 4'hC;
  wire clr    = wr_ctl && reg_wdata[2];
  wire inc    = fifo_push && fifo_cnt != FULL_CNT;
  wire dec    = fifo_pop && fifo_cnt != '0;

  assign rx_busy = force_busy || (hdr_pos + 8'd1 == uhdr);

  always_comb begin
    hi_byte = 8'h00;
    lo_byte = 8'h00;
    case (reg_addr[3:1])
      3'd0: begin hi_byte = {3'b0, lhdr[7:3]};    lo_byte = {lhdr[2:0], 5'b0}; end
      3'd1: begin hi_byte = {3'b0, lorb[10:6]};   lo_byte = {lorb[5:0], 2'b0}; end
      3'd2: begin hi_byte = {3'b0, uhdr[7:3]};    lo_byte = {uhdr[2:0], 5'b0}; end
      3'd3: begin hi_byte = {3'b0, uorb[10:6]};   lo_byte = {uorb[5:0], 2'b0}; end
      3'd4: begin hi_byte = {3'b0, orb_pos[10:6]}; lo_byte = {orb_pos[5:0], 2'b0}; end
      3'd5: begin hi_byte = {3'b0, brst[10:6]};   lo_byte = {brst[5:0], 2'b0}; end
      default: ;
    endcase
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_rd) begin
      if (reg_addr < 4'hC)
        reg_rdata = reg_addr[0] ? shadow : hi_byte;
      else if (reg_addr == 4'hC)
        reg_rdata = {4'b0, fifo_cnt != '0, 1'b0, run, force_busy};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_pos <= '0; lhdr <= '0; uhdr <= '0;
      orb_pos <= '0; lorb <= '0; uorb <= '0; brst <= '0;
      fifo_cnt <= '0; run <= 1'b0; force_busy <= 1'b0; shadow <= '0;
    end else begin
      if (reg_rd && reg_addr < 4'hC && !reg_addr[0])
        shadow <= lo_byte;
      if (bus_reset)
        brst <= orb_pos;
      if (pkt_start) begin
        run  <= 1'b1;
        lhdr <= hdr_pos;
        lorb <= orb_pos;
      end
      if (pkt_done) begin
        run     <= 1'b0;
        hdr_pos <= hdr_pos + 8'(pkt_hdr_blocks);
        orb_pos <= orb_pos + 11'(pkt_orb_quads);
      end
      if (reg_wr) begin
        case (reg_addr)
          4'h4: uhdr[7:3]  <= reg_wdata[4:0];
          4'h5: uhdr[2:0]  <= reg_wdata[7:5];
          4'h6: uorb[10:6] <= reg_wdata[4:0];
          4'h7: uorb[5:0]  <= reg_wdata[7:2];
          4'hC: force_busy <= reg_wdata[0];
          default: ;
        endcase
      end
      if (clr)
        fifo_cnt <= '0;
      else if (inc && !dec)
        fifo_cnt <= fifo_cnt + 1'b1;
      else if (dec && !inc)
        fifo_cnt <= fifo_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rxbuf_ptr_track_chk.sv
module rxbuf_ptr_track_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_reset,
  input logic          pkt_start,
  input logic          pkt_done,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          rx_busy,
  input logic          run,
  input logic          force_busy,
  input logic [CW-1:0] fifo_cnt,
  input logic [7:0]    hdr_pos,
  input logic [10:0]   orb_pos,
  input logic [10:0]   brst
);
  // R4
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> brst == $past(orb_pos));
  // R4
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_reset |=> $stable(brst));
  // R2
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_done |=> $stable(hdr_pos));
  // R9
  run_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start && !pkt_done |=> run);
  // R9
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && !pkt_start |=> !run);
  // R8
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 4'hC && reg_wdata[2] |=> fifo_cnt == '0);
  // R10
  busy_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_busy |-> rx_busy);
endmodule

bind rxbuf_ptr_track rxbuf_ptr_track_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .pkt_start(pkt_start),
  .pkt_done(pkt_done), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .rx_busy(rx_busy), .run(run), .force_busy(force_busy), .fifo_cnt(fifo_cnt),
  .hdr_pos(hdr_pos), .orb_pos(orb_pos), .brst(brst)
);

// File: tb/rxbuf_ptr_track_tb_top.sv
module rxbuf_ptr_track_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic bus_reset = 0, pkt_start = 0, pkt_done = 0;
  logic [3:0] pkt_hdr_blocks = 0;
  logic [10:0] pkt_orb_quads = 0;
  logic fifo_push = 0, fifo_pop = 0, reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic rx_busy;

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit finished = 0;

  int m_hdr, m_lhdr, m_orb, m_lorb, m_uh, m_uo, m_brst, m_fifo, m_shadow;
  bit m_run, m_force;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxbuf_ptr_track #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .pkt_start(pkt_start),
    .pkt_done(pkt_done), .pkt_hdr_blocks(pkt_hdr_blocks), .pkt_orb_quads(pkt_orb_quads),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_busy(rx_busy)
  );

  function automatic int pair_val(int p);
    case (p)
      0: return m_lhdr;
      1: return m_lorb;
      2: return m_uh;
      3: return m_uo;
      4: return m_orb;
      5: return m_brst;
      default: return 0;
    endcase
  endfunction

  function automatic int model_read(int a);
    if (a < 12) return (a % 2) ? m_shadow : ((pair_val(a / 2) >> 8) & 31);
    if (a == 12) return ((m_fifo != 0) << 3) | (m_run << 1) | m_force;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hdr = 0; m_lhdr = 0; m_orb = 0; m_lorb = 0; m_uh = 0; m_uo = 0;
      m_brst = 0; m_fifo = 0; m_shadow = 0; m_run = 0; m_force = 0;
    end else begin
      if (reg_rd && reg_addr < 12 && reg_addr % 2 == 0)
        m_shadow = pair_val(reg_addr / 2) & 255;
      if (bus_reset) m_brst = m_orb;
      if (pkt_start) begin m_run = 1; m_lhdr = m_hdr; m_lorb = m_orb; end
      if (pkt_done) begin
        m_run = 0;
        m_hdr = (m_hdr + 32 * int'(pkt_hdr_blocks)) % 8192;
        m_orb = (m_orb + 4 * int'(pkt_orb_quads)) % 8192;
      end
      if (reg_wr) begin
        case (reg_addr)
          4: m_uh = ((reg_wdata & 31) << 8) | (m_uh & 255);
          5: m_uh = (m_uh & 'h1F00) | (reg_wdata & 'hE0);
          6: m_uo = ((reg_wdata & 31) << 8) | (m_uo & 255);
          7: m_uo = (m_uo & 'h1F00) | (reg_wdata & 'hFC);
          12: m_force = reg_wdata[0];
          default: ;
        endcase
      end
      if (reg_wr && reg_addr == 12 && reg_wdata[2]) m_fifo = 0;
      else begin
        if (fifo_push && !(fifo_pop && m_fifo > 0) && m_fifo < DEPTH) m_fifo++;
        else if (fifo_pop && !fifo_push && m_fifo > 0) m_fifo--;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    check(rx_busy == (m_force || ((m_hdr + 32) % 8192 == m_uh)), "R10", rx_busy,
          m_force || ((m_hdr + 32) % 8192 == m_uh));
    if (reg_rd) check(reg_rdata == model_read(reg_addr), cur_req, reg_rdata, model_read(reg_addr));
  end

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic rd(int a); reg_rd = 1; reg_addr = 4'(a); cyc(); reg_rd = 0; endtask
  task automatic wr(int a, int d); reg_wr = 1; reg_addr = 4'(a); reg_wdata = 8'(d); cyc(); reg_wr = 0; endtask
  task automatic rd_pair(int a); rd(a); rd(a + 1); endtask
  task automatic pkt(int h, int q);
    pkt_start = 1; cyc(); pkt_start = 0;
    cur_req = "R9"; rd(12);
    pkt_hdr_blocks = 4'(h); pkt_orb_quads = 11'(q); pkt_done = 1; cyc(); pkt_done = 0;
  endtask
  task automatic read_ptrs();
    cur_req = "R2"; rd_pair(0);
    cur_req = "R3"; rd_pair(2); rd_pair(8);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(); cyc(); rst_n = 1; cyc();
    // R1 reset state
    cur_req = "R1";
    for (int a = 0; a < 13; a++) rd(a);
    for (int a = 0; a < 12; a += 2) rd_pair(a);

    // R2 R3 varied packets
    pkt(3, 10); read_ptrs();
    pkt(1, 1); read_ptrs();
    pkt(7, 255); read_ptrs();
    cur_req = "R2"; wr(0, 'hFF); wr(1, 'hFF); rd_pair(0);
    cur_req = "R3"; wr(2, 'hFF); wr(3, 'hFF); wr(8, 'hFF); wr(9, 'hFF); rd_pair(2); rd_pair(8);

    // wrap of both areas
    for (int i = 0; i < 20; i++) pkt(15, 2000);
    read_ptrs();

    // R7 latched low byte
    cur_req = "R7"; rd(0); pkt(5, 77); rd(1); rd(8); pkt(2, 9); rd(9); read_ptrs();

    // R5 R6 used pointer masking
    cur_req = "R5"; wr(4, 'hFF); wr(5, 'hFF); rd_pair(4); wr(5, 'h3F); rd_pair(4);
    cur_req = "R6"; wr(6, 'hFF); wr(7, 'hFF); rd_pair(6); wr(7, 'h01); rd_pair(6);

    // R10 full detection
    cur_req = "R10";
    wr(4, ((m_hdr + 32) % 8192) >> 8); wr(5, ((m_hdr + 32) % 8192) & 255);
    check(rx_busy == 1, "R10", rx_busy, 1);
    pkt(1, 4);
    check(rx_busy == 0, "R10", rx_busy, 0);
    wr(12, 1); rd(12); check(rx_busy == 1, "R10", rx_busy, 1);
    wr(12, 0); rd(12);

    // R4 bus reset snapshot
    cur_req = "R4";
    bus_reset = 1; cyc(); bus_reset = 0; rd_pair(10);
    pkt(3, 100);
    bus_reset = 1; cyc(); bus_reset = 0; rd_pair(10);
    wr(10, 'hFF); wr(11, 'hFF); rd_pair(10);
    pkt_start = 1; cyc(); pkt_start = 0;
    pkt_hdr_blocks = 2; pkt_orb_quads = 33; pkt_done = 1; bus_reset = 1; cyc();
    pkt_done = 0; bus_reset = 0; rd_pair(10); rd_pair(8);

    // R8 FIFO flag and clear
    cur_req = "R8"; rd(12);
    fifo_push = 1; cyc(); cyc(); cyc(); fifo_push = 0; rd(12);
    fifo_pop = 1; cyc(); cyc(); cyc(); cyc(); fifo_pop = 0; rd(12);
    fifo_push = 1; for (int i = 0; i < 20; i++) cyc(); fifo_push = 0;
    for (int i = 0; i < DEPTH - 1; i++) begin fifo_pop = 1; cyc(); end
    fifo_pop = 0; rd(12);
    fifo_push = 1; cyc(); cyc(); fifo_push = 0; rd(12);
    wr(12, 4); rd(12);
    fifo_push = 1; cyc(); fifo_push = 0; wr(12, 'h05); rd(12); wr(12, 0); rd(12);

    cyc(); cyc();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule